// File: doc/BRIEF.md
# Bidirectional GPIO Port with Segment Override

This block is an eight-pin general-purpose I/O port seen by software through three small registers on a simple register bus. The registers are a per-pin direction register, an output latch, and a read-only view of the pin levels. Each pin either drives its latched value onto the pad or leaves the pad undriven so that the pad's level can be read. The pad levels reach the read path through a two-flop synchronizer.

A second owner can claim any pin. An external segment-enable bit for each pin hands that pin to a display segment driver. While the bit is set, the port never drives that pad and reads the pin as 0. Software may still write and read back the latch and direction bits of that pin. The stored values take effect again on the pad as soon as the segment releases the pin.

Register addresses are fixed. Address 0 is the pin view, and a write there goes to the latch. Address 1 is the latch. Address 2 is the direction register. Address 3 is unused.

Top module: `gpio_seg_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, every direction bit becomes 1 and every latch bit becomes 0. Right after reset, `pad_oe` is all zeros.
- R2: A pin whose direction bit is 0 and whose `seg_en` bit is 0 has `pad_oe` = 1, and `pad_out` equals that pin's latch bit.
- R3: A pin whose direction bit is 1 has `pad_oe` = 0 and `pad_out` = 0.
- R4: A pin whose `seg_en` bit is 1 has `pad_oe` = 0 and `pad_out` = 0, whatever its direction and latch bits hold.
- R5: A read at address 1 returns the latch contents, not the pad levels.
- R6: A read at address 0 returns the synchronized pad levels. Any bit whose `seg_en` is 1 reads as 0.
- R7: A write at address 0 loads the latch exactly as a write at address 1 does.
- R8: A write at address 2 loads the direction register, and a read at address 2 returns it.
- R9: A pad change shows in an address-0 read after the second rising edge that follows it, and not after the first.
- R10: A write strobed before a rising edge takes effect at that edge and not earlier. With no strobe, the latch and direction registers hold. Address 3 reads 0, and a write there changes nothing.
- R11: While `seg_en` is set, latch and direction writes are still stored and can be read back. Once `seg_en` clears, the pad follows the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| seg_en | input | 8 | Per-pin segment takeover |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| pad_out | output | 8 | Pad output data |

## Verification
A corrupted direction or latch bit shows on `pad_oe`/`pad_out` at once and in the next combinational read. A wrong bit is therefore caught within the cycle after the faulty write. A synchronizer with the wrong depth moves the first visible read of a pad change by one edge. The bench samples after exactly one edge and after exactly two, so either error is caught. A missing segment mask shows at once as a driven pad or a nonzero pin read on a claimed pin.

// File: rtl/gpio_seg_pkg.sv
// Package: shared constants and the register address map for the segment-override GPIO port.
// Assumes a 2-bit register address; the encodings are fixed by the software contract.
package gpio_seg_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADDR_PIN  = 2'd0,
        ADDR_LAT  = 2'd1,
        ADDR_DIR  = 2'd2,
        ADDR_NONE = 2'd3
    } port_addr_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchronizer for each pad input bit.
// Assumes pad inputs are asynchronous to clk; resets both stages to 0 synchronously.
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage1_q;
        logic stage2_q;

        // Shift one pad bit through the two-stage synchronizer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= async_in[b];
                stage2_q <= stage1_q;
            end
        end

        assign sync_out[b] = stage2_q;
    end

endmodule

// File: rtl/gpio_ctl_regs.sv
// Module: direction and output-latch registers written over the register bus.
// Assumes a single-cycle write strobe; writes to the pin address also load the latch.
module gpio_ctl_regs
    import gpio_seg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      lat_q,
    output logic [WIDTH-1:0]      dir_q
);

    port_addr_e addr_e;
    logic       lat_we;
    logic       dir_we;

    // Decode which register the current strobe targets.
    always_comb begin
        addr_e = port_addr_e'(wr_addr);
        lat_we = wr_en && ((addr_e == ADDR_LAT) || (addr_e == ADDR_PIN));
        dir_we = wr_en && (addr_e == ADDR_DIR);
    end

    // Hold the output latch; resets to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (lat_we) begin
            lat_q <= wr_data;
        end
    end

    // Hold the direction register; resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (dir_we) begin
            dir_q <= wr_data;
        end
    end

endmodule

// File: rtl/gpio_pad_gate.sv
// Module: per-pin pad drive gating from direction, latch and segment takeover.
// Assumes dir bit 1 = input; a set seg_en bit wins over any direction setting.
module gpio_pad_gate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] seg_en,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic drive;

        // Drive the pad only when the pin is an output and not claimed by a segment.
        always_comb begin
            drive      = !dir_q[b] && !seg_en[b];
            pad_oe[b]  = drive;
            pad_out[b] = drive && lat_q[b];
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: combinational read-data selection for the register bus.
// Assumes sync_pins is already synchronized; claimed pins read as 0 on the pin address.
module gpio_read_mux
    import gpio_seg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]      sync_pins,
    input  logic [WIDTH-1:0]      seg_en,
    input  logic [WIDTH-1:0]      lat_q,
    input  logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      rd_data
);

    // Pick the register selected by the read address.
    always_comb begin
        case (port_addr_e'(rd_addr))
            ADDR_PIN: rd_data = sync_pins & ~seg_en;
            ADDR_LAT: rd_data = lat_q;
            ADDR_DIR: rd_data = dir_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_seg_port.sv
// Module: top of the segment-override GPIO port.
// Assumes synchronous active-low reset and a register bus with a one-cycle write strobe.
module gpio_seg_port
    import gpio_seg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      seg_en,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_out
);

    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] sync_pins;

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_pins)
    );

    gpio_ctl_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .lat_q   (lat_q),
        .dir_q   (dir_q)
    );

    gpio_pad_gate #(.WIDTH(WIDTH)) u_gate (
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .seg_en  (seg_en),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .rd_addr   (bus_addr),
        .sync_pins (sync_pins),
        .seg_en    (seg_en),
        .lat_q     (lat_q),
        .dir_q     (dir_q),
        .rd_data   (bus_rdata)
    );

endmodule

// File: rtl/gpio_seg_port_chk.sv
// Module: assertion checker bound to gpio_seg_port.
// Assumes it observes the top's ports plus the latch and direction registers.
module gpio_seg_port_chk
    import gpio_seg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]      bus_wdata,
    input logic [WIDTH-1:0]      bus_rdata,
    input logic [WIDTH-1:0]      seg_en,
    input logic [WIDTH-1:0]      pad_in,
    input logic [WIDTH-1:0]      pad_oe,
    input logic [WIDTH-1:0]      pad_out,
    input logic [WIDTH-1:0]      lat_q,
    input logic [WIDTH-1:0]      dir_q
);

    logic [1:0] live_cnt;

    // Count clock edges since reset, saturating at 3, to guard the synchronizer check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= 2'd0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    assert_reset_inputs_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && lat_q == '0));

    assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    assert_seg_owns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & seg_en) == '0);

    assert_pinaddr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_PIN) |=> (lat_q == $past(bus_wdata)));

    assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIR) |=> (dir_q == $past(bus_wdata)));

    assert_two_edge_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && bus_addr == ADDR_PIN)
            |-> (bus_rdata == ($past(pad_in, 2) & ~seg_en)));

    assert_hold_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(lat_q) && $stable(dir_q)));

endmodule

bind gpio_seg_port gpio_seg_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .seg_en    (seg_en),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .lat_q     (lat_q),
    .dir_q     (dir_q)
);

// File: tb/sim_gpio_seg_port.sv
// Bench: sweeps direction, latch, segment and pin patterns; expected values computed arithmetically.
module sim_gpio_seg_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] seg_en = 8'd0;
    logic [7:0] pad_in = 8'd0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_seg_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .seg_en    (seg_en),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk("R1 dir", 2'd2, 8'hFF);
        read_chk("R1 lat", 2'd1, 8'h00);
        check("R1 oe", pad_oe, 8'h00);

        // R2 R3 R4 R5 R8: sweep all direction values against segment patterns
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            logic [7:0] lv;
            dv = 8'(d);
            lv = 8'(d * 37 + 11);
            write_reg(2'd2, dv);
            write_reg(2'd1, lv);
            read_chk("R8 dir readback", 2'd2, dv);
            read_chk("R5 lat readback", 2'd1, lv);
            for (int k = 0; k < 8; k++) begin
                seg_en = 8'(k * 53);
                #1;
                check("R2/R3/R4 oe", pad_oe, ~dv & ~seg_en);
                check("R2/R3/R4 out", pad_out, lv & ~dv & ~seg_en);
            end
            seg_en = 8'h00;
        end

        // R7: pin-address write lands in the latch
        write_reg(2'd0, 8'hC3);
        read_chk("R7 lat via pin addr", 2'd1, 8'hC3);
        write_reg(2'd2, 8'h00);
        #1;
        check("R7 pad_out", pad_out, 8'hC3);

        // R5: latch read ignores pad levels
        @(negedge clk);
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        read_chk("R5 lat not pins", 2'd1, 8'hC3);

        // R9 R6: every pad value, checked after one and two edges
        write_reg(2'd2, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            logic [7:0] prev;
            prev = pad_in;
            seg_en = 8'h00;
            bus_addr = 2'd0;
            pad_in = 8'(p);
            @(negedge clk);
            read_chk("R9 one edge", 2'd0, prev);
            @(negedge clk);
            read_chk("R9 two edges", 2'd0, 8'(p));
            seg_en = 8'(p * 29 + 5);
            read_chk("R6 seg mask", 2'd0, 8'(p) & ~seg_en);
            @(negedge clk);
        end
        seg_en = 8'h00;

        // R10: write takes effect at the edge, not before; unused address
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h5A;
        #1;
        check("R10 before edge", bus_rdata, 8'hC3);
        @(negedge clk);
        bus_wr = 1'b0;
        read_chk("R10 after edge", 2'd1, 8'h5A);
        repeat (3) @(negedge clk);
        read_chk("R10 hold lat", 2'd1, 8'h5A);
        write_reg(2'd3, 8'hE7);
        read_chk("R10 addr3 reads 0", 2'd3, 8'h00);
        read_chk("R10 addr3 lat kept", 2'd1, 8'h5A);
        read_chk("R10 addr3 dir kept", 2'd2, 8'hFF);

        // R11: registers stay writable while segments own the pins
        seg_en = 8'hFF;
        write_reg(2'd1, 8'h96);
        write_reg(2'd2, 8'h0F);
        #1;
        check("R11 oe while seg", pad_oe, 8'h00);
        read_chk("R11 lat while seg", 2'd1, 8'h96);
        read_chk("R11 dir while seg", 2'd2, 8'h0F);
        seg_en = 8'h00;
        #1;
        check("R11 oe released", pad_oe, 8'hF0);
        check("R11 out released", pad_out, 8'h90);

        // R1: reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1 dir after reset", 2'd2, 8'hFF);
        read_chk("R1 lat after reset", 2'd1, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);

        finish_run();
    end

endmodule